// File: doc/BRIEF.md
# Slotted Serial Link Frame Receiver

This block is the receiving end of a fixed-rate slotted serial audio link. A frame is 256 bit times long: a 16-bit tag slot followed by twelve 20-bit data slots. The transmitter launches the frame marker (sync) and the serial data on the rising edge of the bit clock. This receiver samples both on the falling edge, half a bit period later. It locks to each frame on the sync rising transition and decodes the tag slot into a frame-valid flag and a per-slot valid mask. It then turns each data slot into a parallel word.

A data slot is passed on with a one-cycle strobe only when both the frame-valid flag and that slot's tag bit are set. Every other slot is dropped, and its padding is checked: a 1 bit inside a dropped slot sets a sticky flag. The receiver also checks where sync rises and how long it stays high. On a framing fault it raises an error pulse, stops producing strobes and waits for the next sync rising edge. Register decoding, sample handling and the return stream belong to other blocks.

Top module: `acl_link_frame_rx`

## Requirements
- R1: After reset, slot_stb_o, frame_stb_o, frame_err_o, pad_err_o and frame_vld_o read 0, and slot_mask_o reads all zeros.
- R2: A frame starts on the first falling edge that samples sync_i high after a low sample. The data bit sampled on the next falling edge is the frame-valid flag, and frame_vld_o shows it from the end of the tag slot.
- R3: Tag bits 14 down to 3 (tag bit 15 is sent first) give the valid state of slots 1 to 12. slot_mask_o bit j shows the tag bit for slot j+1 from the end of the tag slot.
- R4: Each data slot is 20 bits, received MSB first. At the falling edge of a slot's last bit, slot_word_o takes the whole word, slot_num_o takes the slot number (1 to 12), and slot_stb_o pulses for one cycle.
- R5: slot_stb_o is raised only when the frame-valid flag and that slot's tag bit are both 1. Otherwise no strobe occurs and slot_word_o and slot_num_o keep their values.
- R6: frame_stb_o pulses for one cycle on the last bit of slot 12 of every frame with intact framing, whatever the frame-valid flag is.
- R7: A sync rising edge at any position other than the last bit of the frame makes frame_err_o pulse. No further slot or frame strobe follows until a new frame starts on a later sync rising edge.
- R8: If sync_i is not sampled high on exactly the 16 falling edges from the rising edge through tag bit 1, frame_err_o pulses and the frame is dropped.
- R9: A dropped slot that holds any 1 bit sets pad_err_o. The flag stays set until reset. Zero-filled dropped slots leave it clear.
- R10: A sync rising edge on the last bit of slot 12 starts the next frame with no error. If sync_i stays low there, the receiver goes idle with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock; all state is updated on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame marker from the transmitter |
| sdata_i | input | 1 | Serial data from the transmitter |
| slot_word_o | output | 20 | Last accepted slot word |
| slot_num_o | output | 4 | Slot number (1 to 12) of slot_word_o |
| slot_stb_o | output | 1 | One-cycle pulse when a valid slot is presented |
| frame_stb_o | output | 1 | One-cycle pulse at the end of a well-formed frame |
| frame_vld_o | output | 1 | Frame-valid flag of the current frame |
| slot_mask_o | output | 12 | Tagged-valid slots of the current frame, bit 0 is slot 1 |
| frame_err_o | output | 1 | One-cycle pulse on a framing fault |
| pad_err_o | output | 1 | Sticky flag: nonzero data seen in a dropped slot |

## Verification
A bit counter that is out of step with the frame shows up at once at the ports. The slot strobes land on the wrong bits, the words come out shifted, and a good sync pattern raises frame_err_o within one frame. A lock state that fails to drop after a fault shows as strobes after the error pulse and before the next rising edge. A wrong tag latch shows as a wrong slot_mask_o or frame_vld_o 15 bits into the frame, and as missing or extra strobes later in the same frame. The checks therefore compare every strobe as it arrives against words and masks computed from the transmitted pattern, and they also count frame and error pulses after each directed fault.

// File: rtl/acl_rx_pkg.sv
package acl_rx_pkg;

   typedef enum logic {
      LK_HUNT  = 1'b0,
      LK_TRACK = 1'b1
   } lock_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/acl_rx_framer.sv
module acl_rx_framer
   import acl_rx_pkg::*;
#(
   parameter int TAG_W     = 16,
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   localparam int SEG_W    = $clog2(NUM_SLOTS + 1),
   localparam int POS_W    = $clog2(max_int(TAG_W, SLOT_W))
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sync_i,
   output logic             take_o,
   output logic [SEG_W-1:0] seg_o,
   output logic [POS_W-1:0] pos_o,
   output logic             frame_err_o
);

   lock_e            st_q, st_d;
   logic             sync_q;
   logic [SEG_W-1:0] seg_q, seg_d;
   logic [POS_W-1:0] pos_q, pos_d;
   logic             err_d;

   logic seg_is_tag, last_in_seg, frame_end, rise, sync_bad;

   assign seg_is_tag  = (seg_q == '0);
   assign last_in_seg = seg_is_tag ? (pos_q == POS_W'(TAG_W - 1))
                                   : (pos_q == POS_W'(SLOT_W - 1));
   assign frame_end   = (seg_q == SEG_W'(NUM_SLOTS)) && last_in_seg;
   assign rise        = sync_i && !sync_q;

   // sync must be high over the tag slot except its last bit, low elsewhere;
   // only the last frame bit may carry the next rising edge
   always_comb begin
      if (seg_is_tag)
         sync_bad = last_in_seg ? sync_i : !sync_i;
      else if (frame_end)
         sync_bad = 1'b0;
      else
         sync_bad = sync_i;
   end

   always_comb begin
      st_d  = st_q;
      seg_d = seg_q;
      pos_d = pos_q;
      err_d = 1'b0;
      unique case (st_q)
         LK_HUNT: begin
            if (rise) begin
               st_d  = LK_TRACK;
               seg_d = '0;
               pos_d = '0;
            end
         end
         LK_TRACK: begin
            if (sync_bad) begin
               st_d  = LK_HUNT;
               err_d = 1'b1;
            end else if (frame_end) begin
               seg_d = '0;
               pos_d = '0;
               if (!rise) st_d = LK_HUNT;
            end else if (last_in_seg) begin
               seg_d = seg_q + SEG_W'(1);
               pos_d = '0;
            end else begin
               pos_d = pos_q + POS_W'(1);
            end
         end
         default: st_d = LK_HUNT;
      endcase
   end

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q        <= LK_HUNT;
         sync_q      <= 1'b1;
         seg_q       <= '0;
         pos_q       <= '0;
         frame_err_o <= 1'b0;
      end else begin
         st_q        <= st_d;
         sync_q      <= sync_i;
         seg_q       <= seg_d;
         pos_q       <= pos_d;
         frame_err_o <= err_d;
      end
   end

   assign take_o = (st_q == LK_TRACK) && !sync_bad;
   assign seg_o  = seg_q;
   assign pos_o  = pos_q;

   AST_SHORT_SYNC_FLAGGED: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (st_q == LK_TRACK && seg_q == '0 && pos_q < POS_W'(TAG_W - 1) && !sync_i) |=> frame_err_o); // R8

   AST_EARLY_RISE_FLAGGED: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (st_q == LK_TRACK && seg_q != '0 && !frame_end && rise) |=> frame_err_o); // R7

   AST_ERR_DROPS_LOCK: assert property (@(negedge clk_i) disable iff (!rst_ni)
      frame_err_o |-> (st_q == LK_HUNT)); // R7

endmodule

// File: rtl/acl_rx_shift.sv
module acl_rx_shift #(
   parameter int W = 20
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         take_i,
   input  logic         sd_i,
   output logic [W-1:0] word_o
);

   if (W < 2) begin : g_bad_width
      $error("acl_rx_shift: W must be at least 2");
   end

   logic [W-2:0] sh_q;

   // word including the bit sampled on this edge, MSB first
   assign word_o = {sh_q, sd_i};

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sh_q <= '0;
      else if (take_i) sh_q <= word_o[W-2:0];
   end

endmodule

// File: rtl/acl_rx_slots.sv
module acl_rx_slots
   import acl_rx_pkg::*;
#(
   parameter int TAG_W     = 16,
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   parameter bit PAD_CHECK = 1'b1,
   localparam int SEG_W    = $clog2(NUM_SLOTS + 1),
   localparam int POS_W    = $clog2(max_int(TAG_W, SLOT_W)),
   localparam int SH_W     = max_int(TAG_W, SLOT_W)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 take_i,
   input  logic [SEG_W-1:0]     seg_i,
   input  logic [POS_W-1:0]     pos_i,
   input  logic [SH_W-1:0]      word_i,
   output logic [SLOT_W-1:0]    slot_word_o,
   output logic [SEG_W-1:0]     slot_num_o,
   output logic                 slot_stb_o,
   output logic                 frame_stb_o,
   output logic                 frame_vld_o,
   output logic [NUM_SLOTS-1:0] slot_mask_o,
   output logic                 pad_err_o
);

   logic                 vld_q;
   logic [NUM_SLOTS-1:0] mask_q;
   logic                 tag_end, slot_end, frame_end, sel_tag, slot_ok;
   logic [SLOT_W-1:0]    slot_now;

   assign tag_end   = take_i && (seg_i == '0) && (pos_i == POS_W'(TAG_W - 1));
   assign slot_end  = take_i && (seg_i != '0) && (pos_i == POS_W'(SLOT_W - 1));
   assign frame_end = slot_end && (seg_i == SEG_W'(NUM_SLOTS));
   assign slot_now  = word_i[SLOT_W-1:0];

   // tag bit for slot n sits n places below the frame-valid bit
   logic [NUM_SLOTS-1:0] tag_slots;
   for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_tag_map
      assign tag_slots[j] = word_i[TAG_W-2-j];
   end

   always_comb begin
      sel_tag = 1'b0;
      for (int j = 0; j < NUM_SLOTS; j++)
         if (seg_i == SEG_W'(j + 1)) sel_tag = mask_q[j];
   end

   assign slot_ok = vld_q && sel_tag;

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_q  <= 1'b0;
         mask_q <= '0;
      end else if (tag_end) begin
         vld_q  <= word_i[TAG_W-1];
         mask_q <= tag_slots;
      end
   end

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slot_word_o <= '0;
         slot_num_o  <= '0;
         slot_stb_o  <= 1'b0;
         frame_stb_o <= 1'b0;
      end else begin
         slot_stb_o  <= slot_end && slot_ok;
         frame_stb_o <= frame_end;
         if (slot_end && slot_ok) begin
            slot_word_o <= slot_now;
            slot_num_o  <= seg_i;
         end
      end
   end

   if (PAD_CHECK) begin : g_pad_check
      always_ff @(negedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            pad_err_o <= 1'b0;
         else if (slot_end && !slot_ok && (slot_now != '0))
            pad_err_o <= 1'b1;
      end

      AST_PAD_STICKY: assert property (@(negedge clk_i) disable iff (!rst_ni)
         pad_err_o |=> pad_err_o); // R9
   end else begin : g_no_pad_check
      assign pad_err_o = 1'b0;
   end

   assign frame_vld_o = vld_q;
   assign slot_mask_o = mask_q;

   AST_STB_SPACED: assert property (@(negedge clk_i) disable iff (!rst_ni)
      slot_stb_o |=> !slot_stb_o); // R4

   AST_STB_GATED: assert property (@(negedge clk_i) disable iff (!rst_ni)
      slot_stb_o |-> frame_vld_o); // R5

   AST_FRAME_STB_PULSE: assert property (@(negedge clk_i) disable iff (!rst_ni)
      frame_stb_o |=> !frame_stb_o); // R6

endmodule

// File: rtl/acl_link_frame_rx.sv
module acl_link_frame_rx
   import acl_rx_pkg::*;
#(
   parameter int TAG_W     = 16,
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   parameter bit PAD_CHECK = 1'b1,
   localparam int SEG_W    = $clog2(NUM_SLOTS + 1),
   localparam int POS_W    = $clog2(max_int(TAG_W, SLOT_W)),
   localparam int SH_W     = max_int(TAG_W, SLOT_W)
) (
   input  logic                 bit_clk,
   input  logic                 rst_n,
   input  logic                 sync_i,
   input  logic                 sdata_i,
   output logic [SLOT_W-1:0]    slot_word_o,
   output logic [SEG_W-1:0]     slot_num_o,
   output logic                 slot_stb_o,
   output logic                 frame_stb_o,
   output logic                 frame_vld_o,
   output logic [NUM_SLOTS-1:0] slot_mask_o,
   output logic                 frame_err_o,
   output logic                 pad_err_o
);

   if (NUM_SLOTS < 1 || NUM_SLOTS > TAG_W - 1) begin : g_bad_slots
      $error("acl_link_frame_rx: tag slot too narrow for NUM_SLOTS");
   end
   if (SLOT_W < 2 || TAG_W < 2) begin : g_bad_widths
      $error("acl_link_frame_rx: slot widths must be at least 2");
   end

   logic             take;
   logic [SEG_W-1:0] seg;
   logic [POS_W-1:0] pos;
   logic [SH_W-1:0]  word_now;

   acl_rx_framer #(
      .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
   ) u_framer (
      .clk_i       (bit_clk),
      .rst_ni      (rst_n),
      .sync_i      (sync_i),
      .take_o      (take),
      .seg_o       (seg),
      .pos_o       (pos),
      .frame_err_o (frame_err_o)
   );

   acl_rx_shift #(
      .W(SH_W)
   ) u_shift (
      .clk_i  (bit_clk),
      .rst_ni (rst_n),
      .take_i (take),
      .sd_i   (sdata_i),
      .word_o (word_now)
   );

   acl_rx_slots #(
      .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .PAD_CHECK(PAD_CHECK)
   ) u_slots (
      .clk_i       (bit_clk),
      .rst_ni      (rst_n),
      .take_i      (take),
      .seg_i       (seg),
      .pos_i       (pos),
      .word_i      (word_now),
      .slot_word_o (slot_word_o),
      .slot_num_o  (slot_num_o),
      .slot_stb_o  (slot_stb_o),
      .frame_stb_o (frame_stb_o),
      .frame_vld_o (frame_vld_o),
      .slot_mask_o (slot_mask_o),
      .pad_err_o   (pad_err_o)
   );

   AST_ERR_NO_STROBE: assert property (@(negedge bit_clk) disable iff (!rst_n)
      frame_err_o |-> (!slot_stb_o && !frame_stb_o)); // R7

endmodule

// File: tb/acl_link_frame_rx_tb.sv
module acl_link_frame_rx_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NROWS      = 6;
   // row: {tag[15:0], seed[15:0]}
   localparam logic [31:0] ROWS [NROWS] = '{
      {16'hFFF8, 16'h1234},
      {16'h8000, 16'h0042},
      {16'h7FF8, 16'h0777},
      {16'hA828, 16'h5A5A},
      {16'hC008, 16'h0F0F},
      {16'h9550, 16'h3C3C}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync = 1'b0;
   logic        sd = 1'b0;
   logic [19:0] slot_word;
   logic [3:0]  slot_num;
   logic        slot_stb, frame_stb, frame_vld, frame_err, pad_err;
   logic [11:0] slot_mask;

   always #(CLK_PERIOD/2) clk = ~clk;

   acl_link_frame_rx u_dut (
      .bit_clk     (clk),
      .rst_n       (rst_n),
      .sync_i      (sync),
      .sdata_i     (sd),
      .slot_word_o (slot_word),
      .slot_num_o  (slot_num),
      .slot_stb_o  (slot_stb),
      .frame_stb_o (frame_stb),
      .frame_vld_o (frame_vld),
      .slot_mask_o (slot_mask),
      .frame_err_o (frame_err),
      .pad_err_o   (pad_err)
   );

   int total = 0;
   int fails = 0;
   int frames = 0;
   int errs = 0;
   logic [19:0] exp_word [1:12];
   logic [12:1] exp_vld = '0;
   logic [12:1] seen = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [19:0] slot_val(input int seed, input int n);
      logic [31:0] v;
      v = 32'(seed) * 32'd40503 + 32'(n) * 32'd2654435 ^ (32'(n) << 15);
      return v[19:0] | 20'h00100;
   endfunction

   // monitor: outputs change on the falling edge, read them on the rising edge
   always @(posedge clk) begin
      if (rst_n) begin
         if (slot_stb) begin
            if (slot_num >= 4'd1 && slot_num <= 4'd12) begin
               chk(exp_vld[slot_num], "R5", "strobe on untagged slot", slot_num, 0);
               chk(slot_word == exp_word[slot_num], "R4", "slot word",
                   slot_word, exp_word[slot_num]);
               seen[slot_num] = 1'b1;
            end else begin
               chk(1'b0, "R4", "slot number range", slot_num, 1);
            end
         end
         if (frame_stb) begin
            chk(seen == exp_vld, "R6", "slots seen at frame end", seen, exp_vld);
            frames++;
         end
         if (frame_err) errs++;
      end
   end

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         sync = 1'b0;
         sd   = 1'b0;
      end
   endtask

   task automatic lead_in();
      @(posedge clk);
      sync = 1'b1;
      sd   = 1'b0;
   endtask

   // drives the 256 data bits after the sync rising edge has been presented
   task automatic send_frame(input logic [15:0] tag, input int seed, input int hi_len,
                             input int glitch, input bit dirty, input bit chain);
      for (int i = 0; i < 256; i++) begin
         @(posedge clk);
         if (i < 16) begin
            sd = tag[15-i];
         end else begin
            int n, b;
            logic [19:0] v;
            n = (i - 16) / 20 + 1;
            b = (i - 16) % 20;
            v = (tag[15] && tag[15-n]) || dirty ? slot_val(seed, n) : 20'h0;
            sd = v[19-b];
         end
         sync = (i < hi_len - 1) || (i == glitch) || (chain && i == 255);
         if (i == 5) begin
            for (int n = 1; n <= 12; n++) begin
               exp_word[n] = slot_val(seed, n);
               exp_vld[n]  = (hi_len == 16) && tag[15] && tag[15-n];
            end
            seen = '0;
         end
         if (i == 30 && hi_len == 16) begin
            logic [11:0] m;
            for (int j = 0; j < 12; j++) m[j] = tag[14-j];
            chk(frame_vld == tag[15], "R2", "frame valid flag", frame_vld, tag[15]);
            chk(slot_mask == m, "R3", "slot mask", slot_mask, m);
         end
      end
   endtask

   task automatic check_idle_outputs(input string tagname);
      @(posedge clk);
      chk(slot_stb == 1'b0, tagname, "slot_stb", slot_stb, 0);
      chk(frame_stb == 1'b0, tagname, "frame_stb", frame_stb, 0);
      chk(frame_err == 1'b0, tagname, "frame_err", frame_err, 0);
      chk(pad_err == 1'b0, tagname, "pad_err", pad_err, 0);
      chk(frame_vld == 1'b0, tagname, "frame_vld", frame_vld, 0);
      chk(slot_mask == 12'h0, tagname, "slot_mask", slot_mask, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin : main
      int f0, e0;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      check_idle_outputs("R1");

      // R10: chained frames from the vector table, the last one not chained
      idle(3);
      lead_in();
      for (int r = 0; r < NROWS; r++)
         send_frame(ROWS[r][31:16], int'(ROWS[r][15:0]), 16, -1, 1'b0, r < NROWS - 1);
      idle(4);
      chk(frames == NROWS, "R10", "chained frame count", frames, NROWS);
      chk(errs == 0, "R10", "errors on chained frames", errs, 0);
      chk(pad_err == 1'b0, "R9", "pad flag with zero padding", pad_err, 0);

      // R7: sync rises in the middle of slot 5
      f0 = frames; e0 = errs;
      lead_in();
      send_frame(16'hFFF8, 99, 16, 100, 1'b0, 1'b0);
      idle(4);
      chk(errs == e0 + 1, "R7", "misplaced rise error", errs, e0 + 1);
      chk(frames == f0, "R7", "no frame end after fault", frames, f0);
      lead_in();
      send_frame(16'hB6D8, 7, 16, -1, 1'b0, 1'b0);
      idle(4);
      chk(frames == f0 + 1, "R7", "resync frame", frames, f0 + 1);
      chk(errs == e0 + 1, "R7", "no error after resync", errs, e0 + 1);

      // R8: sync high too short, then too long
      f0 = frames; e0 = errs;
      lead_in();
      send_frame(16'hFFF8, 11, 10, -1, 1'b0, 1'b0);
      idle(4);
      chk(errs == e0 + 1, "R8", "short sync error", errs, e0 + 1);
      lead_in();
      send_frame(16'hFFF8, 12, 20, -1, 1'b0, 1'b0);
      idle(4);
      chk(errs == e0 + 2, "R8", "long sync error", errs, e0 + 2);
      chk(frames == f0, "R8", "faulty frames dropped", frames, f0);

      // R9: dropped slots carrying data
      lead_in();
      send_frame(16'hF000, 21, 16, -1, 1'b1, 1'b0);
      idle(4);
      chk(pad_err == 1'b1, "R9", "pad flag set", pad_err, 1);
      lead_in();
      send_frame(16'hFFF8, 22, 16, -1, 1'b0, 1'b0);
      idle(4);
      chk(pad_err == 1'b1, "R9", "pad flag sticky", pad_err, 1);

      // R1: reset clears the sticky flag and the tag state
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      check_idle_outputs("R1");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule